// File: doc/BRIEF.md
# Windowed Alpha Overlay Compositor

This block places a single foreground layer over a flat background colour on a raster stream. Each incoming pixel arrives with its own x and y coordinates, a sync pair and an RGBA sample. The layer shows only inside a rectangle whose start and end corners are both inclusive. Everywhere else the output carries the programmable background colour.

Inside the rectangle the layer is mixed with the background. The mixing weight comes from one of three sources: the pixel's own alpha, a global alpha, or the product of the two. Two separate gates decide whether the layer takes part at all. The first is the enable bit and source-select field of a channel control word. The second is a routing select that connects the channel to this compositor.

A programmable raster size marks which pixels belong to the frame. Valid pixels outside that raster are dropped, and the sync signals pass through. The pipeline has a fixed depth of two cycles. Configuration inputs are sampled together with the pixel they apply to, so a change can take effect on any pixel.

Top module: `ovl_compositor`

## Requirements
- R1: `out_valid`, `out_hsync` and `out_vsync` equal the values `in_valid` (qualified by R2), `in_hsync` and `in_vsync` had exactly two clock cycles earlier. `out_rgb` belongs to that same pixel.
- R2: `cfg_out_size` holds width minus one in bits [31:16] and height minus one in bits [15:0]. A pixel with x above width minus one, or y above height minus one, gives `out_valid` = 0. Any other valid pixel gives `out_valid` = 1.
- R3: `cfg_win_start` holds x0 in [31:16] and y0 in [15:0]. `cfg_win_end` holds x1 in [31:16] and y1 in [15:0]. The layer is applied only when x0 <= x <= x1 and y0 <= y <= y1, which makes both corners inclusive. Outside this rectangle `out_rgb` equals `cfg_bg_rgb`.
- R4: The control word `cfg_chan_ctrl` is laid out as [3:0] source select, [4] enable, [6:5] alpha mode, [7] layer-factor select, [8] under-factor select and [16:9] global alpha. The layer contributes only when enable is 1 and the source select equals channel index plus one, which is 1 by default. Otherwise the output is the background.
- R5: The layer contributes only when `cfg_route` equals the compositor code, which is 2 by default. A value of 0 or any other code disconnects the layer, and the output is the background.
- R6: Alpha mode 0 (global) uses the global alpha as the weight a.
- R7: Alpha mode 1 (per-pixel) uses the pixel alpha, `in_rgba[7:0]`, as the weight a.
- R8: Alpha mode 2 uses a = round(pixel alpha × global alpha / 255). Mode 3 behaves like mode 0.
- R9: Each colour lane is computed as round((fl·layer + fu·under) / 255). The default factors are fl = a and fu = 255 − a. Input lanes are R = [31:24], G = [23:16] and B = [15:8]. Output lanes are R = [23:16], G = [15:8] and B = [7:0]. `cfg_bg_rgb` uses the same layout as the output.
- R10: When the layer-factor select is 1, fl = 255. When the under-factor select is 1, fu = 0. Any lane result above 255 saturates to 255.
- R11: While `rst_n` is low at a clock edge, every output register clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_hsync | input | 1 | Line sync, delayed to output |
| in_vsync | input | 1 | Frame sync, delayed to output |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| in_rgba | input | 32 | Layer sample R,G,B,A from MSB down |
| cfg_win_start | input | 32 | Window start corner {x0, y0} |
| cfg_win_end | input | 32 | Window end corner {x1, y1}, inclusive |
| cfg_out_size | input | 32 | Raster {width-1, height-1} |
| cfg_chan_ctrl | input | 17 | Channel control word |
| cfg_route | input | 2 | Compositor routing select |
| cfg_bg_rgb | input | 24 | Background colour |
| out_valid | output | 1 | Output pixel qualifier |
| out_hsync | output | 1 | Delayed line sync |
| out_vsync | output | 1 | Delayed frame sync |
| out_rgb | output | 24 | Blended colour |

## Verification
On every cycle the assertions check four behaviours. The sync signals must keep their two-cycle alignment. No output may become valid unless a valid pixel inside the raster width entered two cycles earlier. A disabled layer, or a global weight of zero, must yield exactly the background. The bench scenarios cover what needs arithmetic or geometry that the assertions cannot hold. These are the inclusive window edges on all four sides and the three weight modes with their rounding. They also include the effect of routing and source selection, the factor overrides with saturation, and the reset state.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
// Shared types for the overlay compositor.
// Assumes 8-bit colour lanes and a 17-bit channel control word.
package ovl_pkg;
    localparam int PIX_W   = 8;
    localparam int COORD_W = 16;

    // Source of the blend weight
    typedef enum logic [1:0] {
        AM_GLOBAL  = 2'd0,
        AM_PIXEL   = 2'd1,
        AM_PIX_GLB = 2'd2,
        AM_SPARE   = 2'd3
    } amode_e;

    // Channel control word, MSB first: [16:9] galpha, [8] under_zero,
    // [7] layer_one, [6:5] amode, [4] en, [3:0] src_sel
    typedef struct packed {
        logic [PIX_W-1:0] galpha;
        logic             under_zero;
        logic             layer_one;
        amode_e           amode;
        logic             en;
        logic [3:0]       src_sel;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/ovl_region_hit.sv
`timescale 1ns/1ps
// Classifies a pixel coordinate against the layer window (inclusive
// corners) and the output raster. Purely combinational.
// Assumes corner words pack x in the upper half and y in the lower half.
module ovl_region_hit #(
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  logic [2*COORD_W-1:0] win_start,
    input  logic [2*COORD_W-1:0] win_end,
    input  logic [2*COORD_W-1:0] out_size,
    output logic                 in_win,
    output logic                 in_raster
);
    logic [COORD_W-1:0] x0, y0, x1, y1, wm1, hm1;

    // Split the packed corner and size words
    always_comb begin
        x0  = win_start[2*COORD_W-1:COORD_W];
        y0  = win_start[COORD_W-1:0];
        x1  = win_end[2*COORD_W-1:COORD_W];
        y1  = win_end[COORD_W-1:0];
        wm1 = out_size[2*COORD_W-1:COORD_W];
        hm1 = out_size[COORD_W-1:0];
    end

    // Inclusive window and raster comparisons
    always_comb begin
        in_win    = (x >= x0) && (x <= x1) && (y >= y0) && (y <= y1);
        in_raster = (x <= wm1) && (y <= hm1);
    end
endmodule

// File: rtl/ovl_alpha_gen.sv
`timescale 1ns/1ps
// Selects the effective blend weight from pixel alpha, global alpha,
// or their rounded normalised product. Purely combinational.
// Assumes full scale equals 2**PIX_W - 1.
module ovl_alpha_gen
    import ovl_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  amode_e           mode,
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] glb_a,
    output logic [PIX_W-1:0] eff_a
);
    localparam int PW   = 2*PIX_W + 1;
    localparam int MAXV = (1 << PIX_W) - 1;
    localparam int HALF = MAXV / 2;

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    // Rounded product of the two alphas, rescaled to full scale
    always_comb begin
        prod = PW'(pix_a) * PW'(glb_a) + PW'(HALF);
        quot = prod / PW'(MAXV);
    end

    // Mode selection; the spare code falls back to global
    always_comb begin
        unique case (mode)
            AM_PIXEL:   eff_a = pix_a;
            AM_PIX_GLB: eff_a = quot[PIX_W-1:0];
            default:    eff_a = glb_a;
        endcase
    end
endmodule

// File: rtl/ovl_blend_lane.sv
`timescale 1ns/1ps
// One colour lane: round((fl*layer + fu*under) / MAX), saturated.
// fl is alpha or full scale; fu is (MAX - alpha) or zero.
module ovl_blend_lane #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] layer,
    input  logic [PIX_W-1:0] under,
    input  logic [PIX_W-1:0] alpha,
    input  logic             layer_one,
    input  logic             under_zero,
    output logic [PIX_W-1:0] result
);
    localparam int SW   = 2*PIX_W + 2;
    localparam int MAXV = (1 << PIX_W) - 1;
    localparam int HALF = MAXV / 2;

    logic [PIX_W-1:0] fl, fu;
    logic [SW-1:0]    acc;
    logic [SW-1:0]    quot;

    // Pick the two multiplier factors
    always_comb begin
        fl = layer_one  ? PIX_W'(MAXV) : alpha;
        fu = under_zero ? '0 : PIX_W'(MAXV) - alpha;
    end

    // Weighted sum, rounded division, saturation
    always_comb begin
        acc    = SW'(fl) * SW'(layer) + SW'(fu) * SW'(under) + SW'(HALF);
        quot   = acc / SW'(MAXV);
        result = (quot > SW'(MAXV)) ? PIX_W'(MAXV) : quot[PIX_W-1:0];
    end
endmodule

// File: rtl/ovl_compositor.sv
`timescale 1ns/1ps
// Windowed alpha overlay compositor, two-cycle pipeline.
// Stage 1 classifies the pixel and forms the weight; stage 2 blends.
// Assumes configuration is sampled with the pixel it applies to.
module ovl_compositor
    import ovl_pkg::*;
#(
    parameter int                COORD_W   = 16,
    parameter int                PIX_W     = 8,
    parameter int                LANES     = 3,
    parameter int                CH_ID     = 0,
    parameter int                ROUTE_W   = 2,
    parameter logic [ROUTE_W-1:0] COMP_CODE = 2'd2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_hsync,
    input  logic                        in_vsync,
    input  logic [COORD_W-1:0]          in_x,
    input  logic [COORD_W-1:0]          in_y,
    input  logic [(LANES+1)*PIX_W-1:0]  in_rgba,
    input  logic [2*COORD_W-1:0]        cfg_win_start,
    input  logic [2*COORD_W-1:0]        cfg_win_end,
    input  logic [2*COORD_W-1:0]        cfg_out_size,
    input  logic [CTRL_W-1:0]           cfg_chan_ctrl,
    input  logic [ROUTE_W-1:0]          cfg_route,
    input  logic [LANES*PIX_W-1:0]      cfg_bg_rgb,
    output logic                        out_valid,
    output logic                        out_hsync,
    output logic                        out_vsync,
    output logic [LANES*PIX_W-1:0]      out_rgb
);
    localparam int RGB_W = LANES * PIX_W;
    localparam logic [3:0] SRC_CODE = 4'(CH_ID + 1);

    chan_ctrl_t       ctrl;
    logic             hit_win, hit_raster, layer_on;
    logic [PIX_W-1:0] eff_a;

    logic             s1_valid, s1_hs, s1_vs, s1_on, s1_lone, s1_uzero;
    logic [PIX_W-1:0] s1_alpha;
    logic [RGB_W-1:0] s1_layer, s1_bg, mix_rgb;

    // Decode the control word
    always_comb ctrl = chan_ctrl_t'(cfg_chan_ctrl);

    ovl_region_hit #(.COORD_W(COORD_W)) u_region (
        .x         (in_x),
        .y         (in_y),
        .win_start (cfg_win_start),
        .win_end   (cfg_win_end),
        .out_size  (cfg_out_size),
        .in_win    (hit_win),
        .in_raster (hit_raster)
    );

    ovl_alpha_gen #(.PIX_W(PIX_W)) u_alpha (
        .mode  (ctrl.amode),
        .pix_a (in_rgba[PIX_W-1:0]),
        .glb_a (ctrl.galpha),
        .eff_a (eff_a)
    );

    // Layer takes part only when enabled, selected, routed and in window
    always_comb layer_on = ctrl.en && (ctrl.src_sel == SRC_CODE)
                           && (cfg_route == COMP_CODE) && hit_win;

    // Stage 1: capture classification, weight and colours
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hs    <= 1'b0;
            s1_vs    <= 1'b0;
            s1_on    <= 1'b0;
            s1_lone  <= 1'b0;
            s1_uzero <= 1'b0;
            s1_alpha <= '0;
            s1_layer <= '0;
            s1_bg    <= '0;
        end else begin
            s1_valid <= in_valid && hit_raster;
            s1_hs    <= in_hsync;
            s1_vs    <= in_vsync;
            s1_on    <= layer_on;
            s1_lone  <= ctrl.layer_one;
            s1_uzero <= ctrl.under_zero;
            s1_alpha <= eff_a;
            s1_layer <= in_rgba[(LANES+1)*PIX_W-1:PIX_W];
            s1_bg    <= cfg_bg_rgb;
        end
    end

    // One blend lane per colour component
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ovl_blend_lane #(.PIX_W(PIX_W)) u_lane (
            .layer      (s1_layer[i*PIX_W +: PIX_W]),
            .under      (s1_bg[i*PIX_W +: PIX_W]),
            .alpha      (s1_alpha),
            .layer_one  (s1_lone),
            .under_zero (s1_uzero),
            .result     (mix_rgb[i*PIX_W +: PIX_W])
        );
    end

    // Stage 2: choose blended or background colour, register outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hsync <= 1'b0;
            out_vsync <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_hsync <= s1_hs;
            out_vsync <= s1_vs;
            out_rgb   <= s1_on ? mix_rgb : s1_bg;
        end
    end
endmodule

// File: rtl/ovl_compositor_chk.sv
`timescale 1ns/1ps
// Property checker for ovl_compositor, attached through bind.
// Holds off until two clean cycles after reset so $past is meaningful.
module ovl_compositor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_hsync,
    input logic        in_vsync,
    input logic [15:0] in_x,
    input logic [15:0] size_wm1,
    input logic        ctrl_en,
    input logic [11:0] ctrl_hi,
    input logic [23:0] cfg_bg_rgb,
    input logic        out_valid,
    input logic        out_hsync,
    input logic        out_vsync,
    input logic [23:0] out_rgb
);
    logic [1:0] warm;

    // Count clean cycles since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R1: syncs leave exactly two cycles after they enter
    assert_sync_delay_R1: assert property (@(posedge clk)
        disable iff (!rst_n || warm != 2'd2)
        (out_hsync == $past(in_hsync, 2)) && (out_vsync == $past(in_vsync, 2)));

    // R2: an output pixel needs a valid input inside the raster width
    assert_raster_gate_R2: assert property (@(posedge clk)
        disable iff (!rst_n || warm != 2'd2)
        out_valid |-> ($past(in_valid, 2) && ($past(in_x, 2) <= $past(size_wm1, 2))));

    // R4: a disabled layer leaves the background untouched
    assert_disabled_bg_R4: assert property (@(posedge clk)
        disable iff (!rst_n || warm != 2'd2)
        (out_valid && !$past(ctrl_en, 2)) |-> (out_rgb == $past(cfg_bg_rgb, 2)));

    // R6: global weight zero with default factors yields the background
    assert_zero_weight_R6: assert property (@(posedge clk)
        disable iff (!rst_n || warm != 2'd2)
        (out_valid && $past(ctrl_hi == 12'd0, 2)) |-> (out_rgb == $past(cfg_bg_rgb, 2)));
endmodule

bind ovl_compositor ovl_compositor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_hsync   (in_hsync),
    .in_vsync   (in_vsync),
    .in_x       (in_x),
    .size_wm1   (cfg_out_size[31:16]),
    .ctrl_en    (cfg_chan_ctrl[4]),
    .ctrl_hi    (cfg_chan_ctrl[16:5]),
    .cfg_bg_rgb (cfg_bg_rgb),
    .out_valid  (out_valid),
    .out_hsync  (out_hsync),
    .out_vsync  (out_vsync),
    .out_rgb    (out_rgb)
);

// File: tb/ovl_compositor_test.sv
`timescale 1ns/1ps
// Scoreboard bench: px() drives one pixel per cycle and queues the
// expected result; the monitor pops and compares two cycles later.
module ovl_compositor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
    logic [15:0] in_x = '0, in_y = '0;
    logic [31:0] in_rgba = '0;
    logic [31:0] cfg_win_start = '0, cfg_win_end = '0, cfg_out_size = '0;
    logic [16:0] cfg_chan_ctrl = '0;
    logic [1:0]  cfg_route = '0;
    logic [23:0] cfg_bg_rgb = '0;
    logic        out_valid, out_hsync, out_vsync;
    logic [23:0] out_rgb;

    typedef struct packed {
        int          due;
        logic        v;
        logic        hs;
        logic        vs;
        logic [23:0] rgb;
    } item_t;

    item_t q[$];
    string tags[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    // Shadow configuration applied together with each pixel
    logic [31:0] sh_start, sh_end, sh_size;
    logic [16:0] sh_ctrl;
    logic [1:0]  sh_route;
    logic [23:0] sh_bg;

    ovl_compositor uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hsync(in_hsync),
        .in_vsync(in_vsync), .in_x(in_x), .in_y(in_y), .in_rgba(in_rgba),
        .cfg_win_start(cfg_win_start), .cfg_win_end(cfg_win_end),
        .cfg_out_size(cfg_out_size), .cfg_chan_ctrl(cfg_chan_ctrl),
        .cfg_route(cfg_route), .cfg_bg_rgb(cfg_bg_rgb),
        .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_rgb(out_rgb)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [16:0] mk_ctrl(int src, bit en, int mode,
                                            bit lone, bit uzero, int ga);
        return {8'(ga), uzero, lone, 2'(mode), en, 4'(src)};
    endfunction

    // Expected colour from the requirements
    function automatic logic [23:0] expect_rgb(logic [15:0] x, logic [15:0] y,
                                               logic [31:0] px_rgba);
        int x0, y0, x1, y1, a, pa, ga, fl, fu, v, mode;
        bit on;
        logic [23:0] r;
        x0 = sh_start[31:16]; y0 = sh_start[15:0];
        x1 = sh_end[31:16];   y1 = sh_end[15:0];
        on = sh_ctrl[4] && (sh_ctrl[3:0] == 4'd1) && (sh_route == 2'd2) &&
             (int'(x) >= x0) && (int'(x) <= x1) && (int'(y) >= y0) && (int'(y) <= y1);
        if (!on) return sh_bg;
        pa = px_rgba[7:0];
        ga = sh_ctrl[16:9];
        mode = sh_ctrl[6:5];
        if (mode == 1)      a = pa;
        else if (mode == 2) a = (pa * ga + 127) / 255;
        else                a = ga;
        fl = sh_ctrl[7] ? 255 : a;
        fu = sh_ctrl[8] ? 0 : 255 - a;
        for (int i = 0; i < 3; i++) begin
            v = (fl * int'(px_rgba[8*(i+1) +: 8]) + fu * int'(sh_bg[8*i +: 8]) + 127) / 255;
            if (v > 255) v = 255;
            r[8*i +: 8] = 8'(v);
        end
        return r;
    endfunction

    // Drive one cycle and queue its expected output
    task automatic px(input int x, input int y, input logic [31:0] rgba,
                      input bit v, input bit hs, input bit vs, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        in_x = 16'(x); in_y = 16'(y); in_rgba = rgba;
        in_valid = v; in_hsync = hs; in_vsync = vs;
        cfg_win_start = sh_start; cfg_win_end = sh_end; cfg_out_size = sh_size;
        cfg_chan_ctrl = sh_ctrl; cfg_route = sh_route; cfg_bg_rgb = sh_bg;
        it.due = cyc + 2;
        it.v   = v && (x <= int'(sh_size[31:16])) && (y <= int'(sh_size[15:0]));
        it.hs  = hs;
        it.vs  = vs;
        it.rgb = expect_rgb(16'(x), 16'(y), rgba);
        q.push_back(it);
        tags.push_back(tag);
    endtask

    // Monitor: compare outputs once each queued item falls due
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t e;
                string t;
                e = q.pop_front();
                t = tags.pop_front();
                checks++;
                if (out_valid !== e.v || out_hsync !== e.hs || out_vsync !== e.vs ||
                    (e.v && out_rgb !== e.rgb)) begin
                    fails++;
                    $display("FAIL %s: got v=%0b hs=%0b vs=%0b rgb=%h, expected v=%0b hs=%0b vs=%0b rgb=%h",
                             t, out_valid, out_hsync, out_vsync, out_rgb,
                             e.v, e.hs, e.vs, e.rgb);
                end
            end
        end
    end

    localparam logic [31:0] PIX = 32'hF0801040;

    initial begin
        sh_start = {16'd10, 16'd5};
        sh_end   = {16'd20, 16'd8};
        sh_size  = {16'd63, 16'd47};
        sh_ctrl  = mk_ctrl(1, 1, 0, 0, 0, 255);
        sh_route = 2'd2;
        sh_bg    = 24'h204060;
        in_valid = 1'b1; in_hsync = 1'b1; in_vsync = 1'b1; in_rgba = 32'hFFFFFFFF;

        // R11: reset clears outputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_hsync !== 1'b0 || out_vsync !== 1'b0 || out_rgb !== 24'h0) begin
            fails++;
            $display("FAIL R11: got v=%0b hs=%0b vs=%0b rgb=%h, expected all zero",
                     out_valid, out_hsync, out_vsync, out_rgb);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R3, R6: opaque global weight, inclusive window corners
        px(10, 5, PIX, 1, 0, 0, "R3 start corner");
        px(20, 8, PIX, 1, 0, 0, "R3 end corner");
        px(9, 5, PIX, 1, 0, 0, "R3 left of window");
        px(21, 8, PIX, 1, 0, 0, "R3 right of window");
        px(15, 4, PIX, 1, 0, 0, "R3 above window");
        px(15, 9, PIX, 1, 0, 0, "R3 below window");
        px(15, 6, PIX, 1, 0, 0, "R6 opaque global");

        // R9, R6: half weight blend
        sh_ctrl = mk_ctrl(1, 1, 0, 0, 0, 128);
        px(12, 6, PIX, 1, 0, 0, "R9 global half blend");
        sh_ctrl = mk_ctrl(1, 1, 0, 0, 0, 0);
        px(12, 6, PIX, 1, 0, 0, "R6 zero global");

        // R7: per-pixel weight
        sh_ctrl = mk_ctrl(1, 1, 1, 0, 0, 7);
        px(12, 6, PIX, 1, 0, 0, "R7 pixel alpha 0x40");
        px(12, 6, 32'hF0801000, 1, 0, 0, "R7 pixel alpha 0");
        px(12, 6, 32'hF08010FF, 1, 0, 0, "R7 pixel alpha full");

        // R8: combined weight and spare mode
        sh_ctrl = mk_ctrl(1, 1, 2, 0, 0, 128);
        px(12, 6, PIX, 1, 0, 0, "R8 product weight");
        sh_ctrl = mk_ctrl(1, 1, 2, 0, 0, 255);
        px(12, 6, 32'h3399CC80, 1, 0, 0, "R8 product with full global");
        sh_ctrl = mk_ctrl(1, 1, 3, 0, 0, 200);
        px(12, 6, 32'h3399CC00, 1, 0, 0, "R8 spare mode as global");

        // R4: enable and source select
        sh_ctrl = mk_ctrl(1, 0, 0, 0, 0, 255);
        px(12, 6, PIX, 1, 0, 0, "R4 disabled");
        sh_ctrl = mk_ctrl(2, 1, 0, 0, 0, 255);
        px(12, 6, PIX, 1, 0, 0, "R4 wrong source");
        sh_ctrl = mk_ctrl(0, 1, 0, 0, 0, 255);
        px(12, 6, PIX, 1, 0, 0, "R4 source zero");

        // R5: routing select
        sh_ctrl = mk_ctrl(1, 1, 0, 0, 0, 255);
        sh_route = 2'd0;
        px(12, 6, PIX, 1, 0, 0, "R5 route cleared");
        sh_route = 2'd1;
        px(12, 6, PIX, 1, 0, 0, "R5 other compositor");
        sh_route = 2'd2;
        px(12, 6, PIX, 1, 0, 0, "R5 routed");

        // R2: raster boundaries
        px(64, 3, PIX, 1, 0, 0, "R2 x beyond raster");
        px(3, 48, PIX, 1, 0, 0, "R2 y beyond raster");
        px(63, 47, PIX, 1, 0, 0, "R2 last raster pixel");
        sh_end = {16'd80, 16'd60};
        px(70, 6, PIX, 1, 0, 0, "R2 window past raster");

        // R10: factor overrides and saturation
        sh_end = {16'd20, 16'd8};
        sh_ctrl = mk_ctrl(1, 1, 0, 1, 1, 0);
        px(12, 6, PIX, 1, 0, 0, "R10 layer only");
        sh_ctrl = mk_ctrl(1, 1, 0, 1, 0, 128);
        px(12, 6, PIX, 1, 0, 0, "R10 saturation");
        sh_ctrl = mk_ctrl(1, 1, 0, 0, 1, 128);
        px(12, 6, PIX, 1, 0, 0, "R10 under zero");

        // R1: sync alignment through blanking
        px(0, 0, PIX, 0, 1, 0, "R1 hsync in blank");
        px(0, 0, PIX, 0, 1, 1, "R1 both syncs");
        px(0, 0, PIX, 0, 0, 1, "R1 vsync only");
        px(11, 7, PIX, 1, 1, 0, "R1 valid with hsync");
        px(0, 0, PIX, 0, 0, 0, "R1 idle");
        px(0, 0, PIX, 0, 0, 0, "R1 idle");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        #(5 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule